// File: doc/BRIEF.md
# Buffered SPI Master with Event Unit

This block is a register-programmed SPI master. Software sets the bit rate, the clock polarity and phase, and the character length in a configuration word. It then flushes the queues through a command register, loads outgoing characters into a transmit queue, and writes a start command. The engine shifts each character out on MOSI most significant bit first and captures MISO at the same time. Each received character goes into a receive queue, which software drains through the data register.

A transfer ends by itself. One way is that a character whose "final" flag was set at load time has been shifted. The other way is that the transmit queue runs dry before such a character arrives. Progress and errors are recorded in sticky event bits that software clears by writing ones. The interrupt line is the OR of the events that the mask register leaves unmasked. A multi-master indication from outside only raises an event, and it may be tied low.

Top module: `spim_fifo_master`

Register map (word select `regAddr`): 0 configuration, 1 status (read only), 2 events (write one to clear), 3 mask, 4 command (write only, reads 0), 5 data.

## Requirements
- R1: SCLK toggles every 2*(rate+1) clock cycles while a character is shifting, where rate is configuration bits [5:0]. Consecutive characters keep the same spacing.
- R2: Configuration bit 9 is the SCLK idle level. Bit 10 selects the phase. With phase 0, MOSI is valid before the leading edge and the slave samples on the leading edge. With phase 1, MOSI changes on the leading edge and is sampled on the trailing edge. Bits go out most significant first, and SCLK returns to its idle level after a transfer.
- R3: Configuration bits [8:6] hold the character length minus one. Only bits [len:0] of a written character are sent, and received characters are right-aligned with the upper bits zero.
- R4: Data register writes take the character in bits [7:0] and a final flag in bit 8. Once the flagged character has shifted, the engine stops after exactly 2*(len+1) SCLK edges per character, sets event bit 2 (done) and clears the busy status.
- R5: Command bit 0 clears the receive queue, bit 1 clears the transmit queue, and bit 2 starts a transfer. Nothing shifts before a start. A start is ignored while enable (configuration bit 11) is clear.
- R6: The status bits are: [0] enabled/ready, [1] transmit queue full, [2] receive queue empty, [3] interrupt pending, [4] busy, [5] transmit queue empty.
- R7: The event bits are: [0] transmit space available, [1] receive data present, [2] done, [3] receive overflow, [4] transmit underflow, [5] multi-master. Writing 1 clears a bit. Bits 0 and 1 set again on every cycle their condition holds.
- R8: After reset the mask is 0x3F. The interrupt output is high exactly when some event bit is set whose mask bit is 0.
- R9: Reading the data register returns the oldest received character in bits [7:0] and removes it from the receive queue.
- R10: A data write into a full transmit queue is dropped.
- R11: A character that completes while the receive queue is full is discarded, and event bit 3 is set.
- R12: If the transmit queue is empty at a start, or after a non-final character, the engine stops with SCLK idle and sets event bit 4.
- R13: A high level on the multi-master input sets event bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops receive queue on data reads) |
| regAddr | input | 3 | Register select |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, valid in the cycle of the read |
| mmIn | input | 1 | Multi-master indication |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to slave |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with a queue depth of 4 and keeps the default 8-bit character and 6-bit rate field. The shallow queue lets a few characters fill the transmit queue, so dropped writes, a run that ends in underflow, and receive overflow all occur within a handful of transfers. Random transfers mix every polarity and phase, rates 0 to 3 and several character lengths. A slave model inside the bench checks edge spacing, edge count and both data directions.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
package spim_pkg;
  localparam int EVT_W = 6;
  localparam int EV_TXREQ = 0;
  localparam int EV_RXREQ = 1;
  localparam int EV_DONE  = 2;
  localparam int EV_OVF   = 3;
  localparam int EV_UND   = 4;
  localparam int EV_MM    = 5;

  localparam logic [2:0] A_CFG  = 3'd0;
  localparam logic [2:0] A_STAT = 3'd1;
  localparam logic [2:0] A_EVT  = 3'd2;
  localparam logic [2:0] A_MASK = 3'd3;
  localparam logic [2:0] A_CMD  = 3'd4;
  localparam logic [2:0] A_DATA = 3'd5;

  localparam int CMD_RXCLR = 0;
  localparam int CMD_TXCLR = 1;
  localparam int CMD_START = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadChar;
    logic launch;
    logic sample;
    logic charDone;
    logic txPush;
    logic rxPop;
    logic txClr;
    logic rxClr;
  } spimStb_t;
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
module spim_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign empty  = (wrPtr == rdPtr);
  assign full   = (wrPtr[AW-1:0] == rdPtr[AW-1:0]) && (wrPtr[AW] != rdPtr[AW]);
  assign dout   = mem[rdPtr[AW-1:0]];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doPush && !clr) mem[wrPtr[AW-1:0]] <= din;
  end

  // R10 / R11: a push into a full queue leaves the write side untouched
  a_r10_drop_when_full: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop && !clr) |=> $stable(wrPtr));
  // R9: popping an empty queue does not underflow it
  a_r9_pop_empty_safe: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push && !clr) |=> empty);
endmodule

// File: rtl/spim_datapath.sv
`timescale 1ns/1ps
module spim_datapath
  import spim_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int DEPTH  = 8,
  localparam int LEN_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStb_t          stb,
  input  logic [LEN_W-1:0]  cfgLen,
  input  logic              cfgPha,
  input  logic [CHAR_W:0]   wrData,
  input  logic              miso,
  output logic              mosi,
  output logic              txFull,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              rxEmpty,
  output logic [CHAR_W-1:0] rxHead,
  output logic              curLast
);
  logic [CHAR_W:0]   txHead;
  logic [CHAR_W-1:0] shreg, shNext, lenMask, rxWord;

  spim_fifo #(.WIDTH(CHAR_W+1), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rstN(rstN), .clr(stb.txClr), .push(stb.txPush), .pop(stb.loadChar),
    .din(wrData), .dout(txHead), .full(txFull), .empty(txEmpty));

  spim_fifo #(.WIDTH(CHAR_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rstN(rstN), .clr(stb.rxClr), .push(stb.charDone), .pop(stb.rxPop),
    .din(rxWord), .dout(rxHead), .full(rxFull), .empty(rxEmpty));

  always_comb begin
    for (int i = 0; i < CHAR_W; i++) lenMask[i] = (i <= int'(cfgLen));
    shNext = stb.sample ? {shreg[CHAR_W-2:0], miso} : shreg;
    rxWord = shNext & lenMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg   <= '0;
      curLast <= 1'b0;
      mosi    <= 1'b0;
    end else if (stb.loadChar) begin
      shreg   <= txHead[CHAR_W-1:0];
      curLast <= txHead[CHAR_W];
      if (!cfgPha) mosi <= txHead[cfgLen];
    end else begin
      if (stb.sample) shreg <= shNext;
      if (stb.launch) mosi <= shreg[cfgLen];
    end
  end

  // R12: control never loads a character from an empty transmit queue
  a_r12_load_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadChar |-> !txEmpty);
  // R2: a bit is never launched and sampled in the same half period edge
  a_r2_edge_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.launch && stb.sample));
endmodule

// File: rtl/spim_control.sv
`timescale 1ns/1ps
module spim_control
  import spim_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int BRG_W  = 6,
  localparam int LEN_W = $clog2(CHAR_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              mmIn,
  output logic              sclk,
  output logic              irq,
  output spimStb_t          stb,
  output logic [LEN_W-1:0]  cfgLen,
  output logic              cfgPha,
  output logic [CHAR_W:0]   wrData,
  input  logic              txFull,
  input  logic              txEmpty,
  input  logic              rxFull,
  input  logic              rxEmpty,
  input  logic [CHAR_W-1:0] rxHead,
  input  logic              curLast
);
  localparam int DIV_W  = BRG_W + 2;
  localparam int HALF_W = LEN_W + 2;
  localparam int POL_B  = BRG_W + LEN_W;
  localparam int PHA_B  = POL_B + 1;
  localparam int EN_B   = POL_B + 2;

  typedef enum logic {S_IDLE, S_SHIFT} state_t;

  state_t            state;
  logic [BRG_W-1:0]  cfgRate;
  logic              cfgPol, cfgEn;
  logic [EVT_W-1:0]  evt, mask, evtSet, evtClr;
  logic [DIV_W-1:0]  divCnt, divLim;
  logic [HALF_W-1:0] halfCnt, lastHalf;
  logic              sclkPhase;
  logic              wrCfg, wrEvt, wrMask, wrCmd, wrDat, rdDat;
  logic              edgeNow, lead, charEnd, startOk, stopDone, stopUnd;
  logic [31:0]       unusedBits;

  assign unusedBits = {regWdata[31:EN_B+1], 1'b0};

  assign wrCfg  = regWrEn && (regAddr == A_CFG);
  assign wrEvt  = regWrEn && (regAddr == A_EVT);
  assign wrMask = regWrEn && (regAddr == A_MASK);
  assign wrCmd  = regWrEn && (regAddr == A_CMD);
  assign wrDat  = regWrEn && (regAddr == A_DATA);
  assign rdDat  = regRdEn && (regAddr == A_DATA);
  assign wrData = regWdata[CHAR_W:0];

  assign divLim   = {1'b0, cfgRate, 1'b1};
  assign lastHalf = {1'b0, cfgLen, 1'b1};
  assign edgeNow  = (state == S_SHIFT) && (divCnt == divLim);
  assign lead     = ~halfCnt[0];
  assign charEnd  = edgeNow && !lead && (halfCnt == lastHalf);
  assign startOk  = wrCmd && regWdata[CMD_START] && cfgEn && (state == S_IDLE);
  assign stopDone = charEnd && curLast;
  assign stopUnd  = (startOk && txEmpty) || (charEnd && !curLast && txEmpty);

  always_comb begin
    stb          = '0;
    stb.launch   = edgeNow && (lead ? cfgPha : ~cfgPha);
    stb.sample   = edgeNow && (lead ? ~cfgPha : cfgPha);
    stb.charDone = charEnd;
    stb.loadChar = (startOk && !txEmpty) || (charEnd && !curLast && !txEmpty);
    stb.txPush   = wrDat;
    stb.rxPop    = rdDat && !rxEmpty;
    stb.txClr    = wrCmd && regWdata[CMD_TXCLR];
    stb.rxClr    = wrCmd && regWdata[CMD_RXCLR];
  end

  always_comb begin
    evtSet           = '0;
    evtSet[EV_TXREQ] = !txFull;
    evtSet[EV_RXREQ] = !rxEmpty;
    evtSet[EV_DONE]  = stopDone;
    evtSet[EV_OVF]   = charEnd && rxFull;
    evtSet[EV_UND]   = stopUnd;
    evtSet[EV_MM]    = mmIn;
    evtClr           = wrEvt ? regWdata[EVT_W-1:0] : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgRate <= '0;
      cfgLen  <= LEN_W'(CHAR_W - 1);
      cfgPol  <= 1'b0;
      cfgPha  <= 1'b0;
      cfgEn   <= 1'b0;
      mask    <= '1;
      evt     <= '0;
    end else begin
      if (wrCfg) begin
        cfgRate <= regWdata[BRG_W-1:0];
        cfgLen  <= regWdata[POL_B-1:BRG_W];
        cfgPol  <= regWdata[POL_B];
        cfgPha  <= regWdata[PHA_B];
        cfgEn   <= regWdata[EN_B];
      end
      if (wrMask) mask <= regWdata[EVT_W-1:0];
      evt <= (evt & ~evtClr) | evtSet;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      divCnt    <= '0;
      halfCnt   <= '0;
      sclkPhase <= 1'b0;
    end else if (state == S_IDLE) begin
      if (startOk && !txEmpty) begin
        state     <= S_SHIFT;
        divCnt    <= '0;
        halfCnt   <= '0;
        sclkPhase <= 1'b0;
      end
    end else if (edgeNow) begin
      divCnt    <= '0;
      sclkPhase <= ~sclkPhase;
      halfCnt   <= halfCnt + 1'b1;
      if (charEnd) begin
        halfCnt <= '0;
        if (!stb.loadChar) state <= S_IDLE;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign sclk = cfgPol ^ sclkPhase;
  assign irq  = |(evt & ~mask);

  always_comb begin
    regRdata = '0;
    case (regAddr)
      A_CFG:  regRdata[EN_B:0] = {cfgEn, cfgPha, cfgPol, cfgLen, cfgRate};
      A_STAT: regRdata[5:0] = {txEmpty, state == S_SHIFT, irq, rxEmpty, txFull, cfgEn};
      A_EVT:  regRdata[EVT_W-1:0] = evt;
      A_MASK: regRdata[EVT_W-1:0] = mask;
      A_DATA: regRdata[CHAR_W-1:0] = rxHead;
      default: regRdata = '0;
    endcase
  end

  // R1: SCLK holds between divider terminal counts
  a_r1_hold_between_ticks: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SHIFT && divCnt != divLim) |=> $stable(sclkPhase));
  // R4: a finished final character stops the engine and records done
  a_r4_stop_on_final: assert property (@(posedge clk) disable iff (!rstN)
    stopDone |=> (evt[EV_DONE] && state == S_IDLE));
  // R11: completing into a full receive queue records overflow
  a_r11_overflow_event: assert property (@(posedge clk) disable iff (!rstN)
    (charEnd && rxFull) |=> evt[EV_OVF]);
  // R12: underflow stops the engine with SCLK at idle
  a_r12_underflow_stop: assert property (@(posedge clk) disable iff (!rstN)
    stopUnd |=> (evt[EV_UND] && state == S_IDLE && sclkPhase == 1'b0));
  // R5: a start while disabled leaves the engine idle
  a_r5_start_gated: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !cfgEn) |=> state == S_IDLE);
endmodule

// File: rtl/spim_fifo_master.sv
`timescale 1ns/1ps
module spim_fifo_master
  import spim_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int BRG_W  = 6,
  parameter int DEPTH  = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  output logic [31:0] regRdata,
  input  logic        mmIn,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        irq
);
  localparam int LEN_W = $clog2(CHAR_W);

  spimStb_t          stb;
  logic [LEN_W-1:0]  cfgLen;
  logic              cfgPha, txFull, txEmpty, rxFull, rxEmpty, curLast;
  logic [CHAR_W:0]   wrData;
  logic [CHAR_W-1:0] rxHead;

  spim_control #(.CHAR_W(CHAR_W), .BRG_W(BRG_W)) u_ctl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mmIn(mmIn), .sclk(sclk), .irq(irq),
    .stb(stb), .cfgLen(cfgLen), .cfgPha(cfgPha), .wrData(wrData),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .rxHead(rxHead), .curLast(curLast));

  spim_datapath #(.CHAR_W(CHAR_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgLen(cfgLen), .cfgPha(cfgPha),
    .wrData(wrData), .miso(miso), .mosi(mosi), .txFull(txFull), .txEmpty(txEmpty),
    .rxFull(rxFull), .rxEmpty(rxEmpty), .rxHead(rxHead), .curLast(curLast));
endmodule

// File: tb/spim_fifo_master_tb.sv
`timescale 1ns/1ps
module spim_fifo_master_tb;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0, mmIn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic sclk, mosi, irq, miso;

  always #4 clk = ~clk;

  spim_fifo_master #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .mmIn(mmIn), .miso(miso),
    .sclk(sclk), .mosi(mosi), .irq(irq));

  int nChk = 0, nFail = 0;
  // slave model state
  int tbLen = 7;
  logic tbPol = 1'b0, tbPha = 1'b0;
  logic [7:0] resp [0:8];
  logic [7:0] cap  [0:8];
  logic [7:0] txb  [0:8];
  logic [7:0] saved [0:8];
  int respIdx = 0, capIdx = 0, sBit = 0, edgeCnt = 0;
  logic [7:0] sRx = '0;
  bit slvOn = 1'b0;
  longint lastT = 0, minGap = 0, maxGap = 0;

  assign miso = resp[respIdx][tbLen - sBit];

  function automatic logic [7:0] lmask(input int len);
    return 8'((1 << (len + 1)) - 1);
  endfunction

  function automatic logic [31:0] cfgWord(input int rate, input int len, input logic pol,
                                          input logic pha, input logic en);
    return 32'(rate) | (32'(len) << 6) | (32'(pol) << 9) | (32'(pha) << 10) | (32'(en) << 11);
  endfunction

  always @(sclk) begin
    if (slvOn) begin
      edgeCnt++;
      if (edgeCnt > 1) begin
        if (edgeCnt == 2 || ($time - lastT) < minGap) minGap = $time - lastT;
        if (edgeCnt == 2 || ($time - lastT) > maxGap) maxGap = $time - lastT;
      end
      lastT = $time;
      if (sclk != tbPol) begin
        if (!tbPha) sRx = {sRx[6:0], mosi};
      end else begin
        if (tbPha) sRx = {sRx[6:0], mosi};
        sBit++;
        if (sBit == tbLen + 1) begin
          cap[capIdx] = sRx & lmask(tbLen);
          capIdx++;
          sRx = '0;
          sBit = 0;
          if (respIdx < 8) respIdx++;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a; regRdEn = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic slvPrep();
    respIdx = 0; capIdx = 0; sBit = 0; sRx = '0; edgeCnt = 0;
    minGap = 0; maxGap = 0; slvOn = 1'b1;
  endtask

  task automatic startWait();
    logic [31:0] s;
    wr(3'd4, 32'h4);
    for (int k = 0; k < 3000; k++) begin
      rd(3'd1, s);
      if (!s[4]) break;
    end
    slvOn = 1'b0;
  endtask

  initial begin
    #(8 * 190000);
    nFail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n, rate, len;
    logic pol, pha;
    void'($urandom(32'd1234));
    for (int i = 0; i < 9; i++) begin resp[i] = '0; cap[i] = '0; end

    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // reset state
    rd(3'd1, d); chk("R6 reset status", d, 32'h24);
    rd(3'd3, d); chk("R8 reset mask", d, 32'h3F);
    chk("R8 irq low at reset", {31'd0, irq}, 32'd0);
    rd(3'd2, d); chk("R7 txReq set when space", d, 32'h01);

    // start while disabled is ignored; tx clear
    wr(3'd0, cfgWord(0, 7, 1'b0, 1'b0, 1'b0));
    wr(3'd5, 32'h1A5);
    slvPrep();
    wr(3'd4, 32'h4);
    repeat (20) @(negedge clk);
    slvOn = 1'b0;
    chk("R5 no edges when disabled", 32'(edgeCnt), 32'd0);
    rd(3'd1, d); chk("R5 status after ignored start", d & 32'h31, 32'h00);
    wr(3'd4, 32'h2);
    rd(3'd1, d); chk("R5 tx clear empties queue", d[5], 1);

    // start with empty queue -> underflow
    wr(3'd0, cfgWord(1, 7, 1'b1, 1'b0, 1'b1));
    slvPrep();
    startWait();
    rd(3'd2, d); chk("R12 underflow on empty start", d[4], 1);
    chk("R12 no edges on empty start", 32'(edgeCnt), 32'd0);
    chk("R12 sclk idle after underflow", {31'd0, sclk}, 32'd1);
    wr(3'd2, 32'h3F);

    // random transfers
    for (int it = 0; it < 10; it++) begin
      n = $urandom_range(1, DEPTH);
      rate = $urandom_range(0, 3);
      len = (it == 3) ? 4 : ((it == 6) ? 2 : 7);
      pol = 1'($urandom_range(0, 1));
      pha = 1'($urandom_range(0, 1));
      tbLen = len; tbPol = pol; tbPha = pha;
      wr(3'd0, cfgWord(rate, len, pol, pha, 1'b1));
      wr(3'd4, 32'h3);
      for (int j = 0; j < n; j++) begin
        txb[j] = 8'($urandom_range(0, 255));
        resp[j] = 8'($urandom_range(0, 255));
        wr(3'd5, {23'd0, (j == n - 1), txb[j]});
      end
      resp[n] = '0;
      slvPrep();
      startWait();
      rd(3'd2, d); chk("R4 done event after final char", d[2], 1);
      chk("R4 edge count", 32'(edgeCnt), 32'(2 * (len + 1) * n));
      chk("R1 min half period", 32'(minGap), 32'(16 * (rate + 1)));
      chk("R1 max half period", 32'(maxGap), 32'(16 * (rate + 1)));
      chk("R2 sclk idles at polarity", {31'd0, sclk}, {31'd0, pol});
      for (int j = 0; j < n; j++) begin
        chk(len == 7 ? "R2 slave captured mosi" : "R3 short char sent",
            {24'd0, cap[j]}, {24'd0, txb[j] & lmask(len)});
        rd(3'd5, d);
        chk(len == 7 ? "R9 received byte" : "R3 short char right-aligned",
            d, {24'd0, resp[j] & lmask(len)});
      end
      rd(3'd1, d); chk("R9 rx empty after draining", d[2], 1);
      wr(3'd2, 32'h3C);
    end

    // full transmit queue drops write, run ends in underflow
    tbLen = 7; tbPol = 1'b0; tbPha = 1'b0;
    wr(3'd0, cfgWord(0, 7, 1'b0, 1'b0, 1'b1));
    for (int j = 0; j < DEPTH; j++) begin
      txb[j] = 8'($urandom_range(0, 255));
      resp[j] = 8'($urandom_range(0, 255));
      saved[j] = resp[j];
      wr(3'd5, {24'd0, txb[j]});
    end
    rd(3'd1, d); chk("R6 tx full status", d[1], 1);
    wr(3'd5, 32'h1FF);
    slvPrep();
    startWait();
    rd(3'd2, d);
    chk("R10 dropped final write leads to underflow", d[4], 1);
    chk("R12 no done after underflow", d[2], 0);
    chk("R10 only queued chars sent", 32'(capIdx), 32'(DEPTH));
    chk("R2 last kept char", {24'd0, cap[DEPTH - 1]}, {24'd0, txb[DEPTH - 1]});
    wr(3'd2, 32'h3C);

    // receive overflow
    rd(3'd1, d); chk("R6 rx not empty", d[2], 0);
    resp[0] = 8'h5C;
    wr(3'd5, 32'h1C3);
    slvPrep();
    startWait();
    rd(3'd2, d); chk("R11 overflow event", d[3], 1);
    for (int j = 0; j < DEPTH; j++) begin
      rd(3'd5, d); chk("R11 older bytes kept", d, {24'd0, saved[j]});
    end
    rd(3'd1, d); chk("R11 overflowed byte discarded", d[2], 1);

    // write-one-to-clear
    wr(3'd2, 32'h3E);
    rd(3'd2, d); chk("R7 w1c clears, txReq reasserts", d, 32'h01);

    // multi-master event and irq masking
    @(negedge clk); mmIn = 1'b1;
    @(negedge clk); mmIn = 1'b0;
    rd(3'd2, d); chk("R13 multi-master event", d[5], 1);
    chk("R8 masked event keeps irq low", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h1F);
    #1 chk("R8 unmasked event raises irq", {31'd0, irq}, 32'd1);
    rd(3'd1, d); chk("R6 irq summary bit", d[3], 1);
    wr(3'd2, 32'h20);
    #1 chk("R8 irq drops after clear", {31'd0, irq}, 32'd0);

    // rx clear command
    wr(3'd5, 32'h181);
    resp[0] = 8'h11;
    slvPrep();
    startWait();
    wr(3'd4, 32'h1);
    rd(3'd1, d); chk("R5 rx clear empties queue", d[2], 1);

    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule